// File: doc/BRIEF.md
# Indirect Memory Window With Mailboxes

This block is a byte-wide register slave that sits between a host bus and a small on-chip memory owned by an embedded controller. The host cannot see that memory directly. It programs a 16-bit pointer whose top fourteen bits select a 32-bit word and whose bottom two bits select how the four-byte data window behaves. It then moves data through that window. Each pointer write fetches the selected word into a window buffer. Writes through the window are merged into that buffer and are committed to memory at a point set by the access mode. In the streaming mode the pointer steps one word forward after each complete word, so a block of data can be moved with no pointer rewrites.

Two 8-bit mailboxes carry messages. The host-to-controller mailbox is written by the host and shown to the controller on a port. The controller-to-host mailbox is loaded from the controller side, and the host empties it by writing back the value it read. A 16-bit event register collects controller events and mailbox activity. The host clears its bits with write-one-to-clear writes, one byte at a time. A 16-bit enable register selects which events drive the registered host interrupt line.

Host accesses are single-cycle byte strobes on a 4-bit offset. Read data appears on the clock edge after the read strobe. After a pointer write or a stream step, the window holds the new word two clock edges later, and the host leaves that gap before the next window access.

Top module: `ecw_host_window`

## Requirements
- R1: After reset, every register reads 0, `hst_rdata` is 0, `hst_irq` is 0 and `ctl_h2c_mbox` is 0.
- R2: Offsets decode as follows: 0x0 is the host-to-controller mailbox, 0x1 the controller-to-host mailbox, 0x2/0x3 the pointer low/high byte, 0x4–0x7 window bytes 0–3, 0x8/0x9 the event register low/high byte, and 0xA/0xB the enable register low/high byte. Offsets 0xC–0xF read 0. Read data is valid on the edge after `hst_re`.
- R3: The pointer's bits [1:0] hold the mode: 0 is byte, 1 is halfword, 2 is word, 3 is word with auto-step. Bits [15:2] hold the word address. In byte mode, a write to window offset 0x4+k commits only byte k of the addressed word, and the other three bytes are unchanged.
- R4: In halfword mode, a write to window byte 0 or 2 only updates the buffer. A write to byte 1 or 3 commits the halfword that holds it (bytes 0–1 or bytes 2–3).
- R5: In word mode, writes to window bytes 0–2 leave memory unchanged. A write to byte 3 commits all four buffered bytes. Writes to any other offset never write memory.
- R6: In auto-step mode, a write to byte 3 commits the word. That write, or a read of byte 3, then advances the word address by one, leaves the mode bits at 3, and reloads the window from the next word.
- R7: A host write to offset 0x0 stores the byte, which reads back at 0x0 and appears on `ctl_h2c_mbox`. It also sets event bit 0.
- R8: A pulse on `ctl_c2h_we` loads `ctl_c2h_data` into the controller-to-host mailbox and sets event bit 1. A host write to offset 0x1 clears the mailbox bits written as one, so writing back the value read empties the mailbox. Writing 0 changes nothing.
- R9: Bits set in `ctl_evt` set the matching event bits. A host write to 0x8 or 0x9 clears the bits written as one in that byte only, and writing 0 has no effect.
- R10: The enable register is read and written per byte. `hst_irq` goes high one edge after the AND of the events and the enables becomes non-zero, and low one edge after it becomes zero. With the enables at 0, `hst_irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host byte write strobe |
| hst_re | input | 1 | Host byte read strobe |
| hst_ofs | input | 4 | Register offset |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Registered host read byte |
| hst_irq | output | 1 | Registered host interrupt |
| ctl_h2c_mbox | output | 8 | Host-to-controller mailbox contents |
| ctl_c2h_we | input | 1 | Controller mailbox load strobe |
| ctl_c2h_data | input | 8 | Controller mailbox load byte |
| ctl_evt | input | 16 | Controller event set pulses |

## Verification
The window is driven with every access mode against the same words in memory. Each write pattern is followed by a pointer rewrite, which forces a fresh fetch, so the bytes read back show what memory holds and not what the buffer holds. Partial word and halfword writes tell a correct commit point apart from an early one, and a single byte-mode write next to known neighbours exposes byte enables that are too wide. A three-word streaming write followed by a streaming read checks both the step order and the final pointer value. Event patterns that span both bytes, combined with zero writes and selective enables, tell per-byte clearing apart from whole-register clearing and show the one-edge interrupt latency.

// File: rtl/ecw_pkg.sv
package ecw_pkg;

  typedef enum logic [1:0] {
    AM_BYTE   = 2'd0,
    AM_HALF   = 2'd1,
    AM_WORD   = 2'd2,
    AM_STREAM = 2'd3
  } acc_mode_e;

  localparam int EVT_W = 16;

  localparam logic [3:0] OFS_H2C  = 4'h0;
  localparam logic [3:0] OFS_C2H  = 4'h1;
  localparam logic [3:0] OFS_PTRL = 4'h2;
  localparam logic [3:0] OFS_PTRH = 4'h3;
  localparam logic [3:0] OFS_EVTL = 4'h8;
  localparam logic [3:0] OFS_EVTH = 4'h9;
  localparam logic [3:0] OFS_ENL  = 4'hA;
  localparam logic [3:0] OFS_ENH  = 4'hB;

  // byte enables that a window write in a given mode stores
  function automatic logic [3:0] lane_be(acc_mode_e m, logic [1:0] k);
    case (m)
      AM_BYTE: lane_be = 4'b0001 << k;
      AM_HALF: lane_be = k[1] ? 4'b1100 : 4'b0011;
      default: lane_be = 4'b1111;
    endcase
  endfunction

  // does a window write to lane k end the unit for this mode
  function automatic logic lane_commit(acc_mode_e m, logic [1:0] k);
    case (m)
      AM_BYTE: lane_commit = 1'b1;
      AM_HALF: lane_commit = k[0];
      default: lane_commit = (k == 2'd3);
    endcase
  endfunction

endpackage

// File: rtl/ecw_ram.sv
module ecw_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NB; b++) begin
        if (be[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/ecw_window.sv
module ecw_window
  import ecw_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_we,
  input  logic              hst_re,
  input  logic [3:0]        hst_ofs,
  input  logic [7:0]        hst_wdata,
  output logic [15:0]       ptr_q,
  output logic [31:0]       win_q,
  output logic              ram_we,
  output logic              ram_re,
  output logic [MEM_AW-1:0] ram_addr,
  output logic [3:0]        ram_be,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata
);
  localparam int WA_W = 14;

  acc_mode_e   mode;
  logic [1:0]  lane;
  logic        win_sel, wr_win, rd_last, commit, step, ptr_wr;
  logic        fetch_q, load_q;
  logic [31:0] merged;

  assign mode    = acc_mode_e'(ptr_q[1:0]);
  assign lane    = hst_ofs[1:0];
  assign win_sel = (hst_ofs[3:2] == 2'b01);
  assign wr_win  = hst_we && win_sel;
  assign rd_last = hst_re && win_sel && (lane == 2'd3) && (mode == AM_STREAM);
  assign commit  = wr_win && lane_commit(mode, lane);
  assign step    = (commit && (mode == AM_STREAM)) || rd_last;
  assign ptr_wr  = hst_we && ((hst_ofs == OFS_PTRL) || (hst_ofs == OFS_PTRH));

  always_comb begin
    merged = win_q;
    merged[lane*8 +: 8] = hst_wdata;
  end

  assign ram_we    = commit;
  assign ram_be    = lane_be(mode, lane);
  assign ram_wdata = merged;
  assign ram_re    = fetch_q;
  assign ram_addr  = ptr_q[2 +: MEM_AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      win_q   <= '0;
      fetch_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      fetch_q <= ptr_wr || step;
      load_q  <= fetch_q;
      if (hst_we && hst_ofs == OFS_PTRL)      ptr_q[7:0]  <= hst_wdata;
      else if (hst_we && hst_ofs == OFS_PTRH) ptr_q[15:8] <= hst_wdata;
      else if (step) ptr_q[15:2] <= ptr_q[15:2] + WA_W'(1);
      if (wr_win)      win_q <= merged;
      else if (load_q) win_q <= ram_rdata;
    end
  end

endmodule

// File: rtl/ecw_intc.sv
module ecw_intc
  import ecw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_we,
  input  logic [3:0]       hst_ofs,
  input  logic [7:0]       hst_wdata,
  input  logic             ctl_c2h_we,
  input  logic [7:0]       ctl_c2h_data,
  input  logic [EVT_W-1:0] ctl_evt,
  output logic [7:0]       h2c_q,
  output logic [7:0]       c2h_q,
  output logic [EVT_W-1:0] evt_q,
  output logic [EVT_W-1:0] en_q,
  output logic             irq_q
);
  logic             h2c_wr;
  logic [EVT_W-1:0] set_v, clr_v;

  assign h2c_wr = hst_we && (hst_ofs == OFS_H2C);

  always_comb begin
    set_v    = ctl_evt;
    set_v[0] = set_v[0] | h2c_wr;
    set_v[1] = set_v[1] | ctl_c2h_we;
    clr_v    = '0;
    if (hst_we && hst_ofs == OFS_EVTL) clr_v[7:0]  = hst_wdata;
    if (hst_we && hst_ofs == OFS_EVTH) clr_v[15:8] = hst_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h2c_q <= '0;
      c2h_q <= '0;
      evt_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (h2c_wr) h2c_q <= hst_wdata;
      if (ctl_c2h_we) c2h_q <= ctl_c2h_data;
      else if (hst_we && hst_ofs == OFS_C2H) c2h_q <= c2h_q & ~hst_wdata;
      evt_q <= (evt_q & ~clr_v) | set_v;
      if (hst_we && hst_ofs == OFS_ENL) en_q[7:0]  <= hst_wdata;
      if (hst_we && hst_ofs == OFS_ENH) en_q[15:8] <= hst_wdata;
      irq_q <= |(evt_q & en_q);
    end
  end

endmodule

// File: rtl/ecw_host_window.sv
module ecw_host_window
  import ecw_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hst_we,
  input  logic        hst_re,
  input  logic [3:0]  hst_ofs,
  input  logic [7:0]  hst_wdata,
  output logic [7:0]  hst_rdata,
  output logic        hst_irq,
  output logic [7:0]  ctl_h2c_mbox,
  input  logic        ctl_c2h_we,
  input  logic [7:0]  ctl_c2h_data,
  input  logic [15:0] ctl_evt
);
  logic [15:0]       w_ptr;
  logic [31:0]       w_win;
  logic              w_ram_we, w_ram_re;
  logic [MEM_AW-1:0] w_ram_addr;
  logic [3:0]        w_ram_be;
  logic [31:0]       w_ram_wdata, w_ram_rdata;
  logic [7:0]        w_h2c, w_c2h;
  logic [15:0]       w_evt, w_en;
  logic [7:0]        rd_mux, rdata_q;

  ecw_window #(.MEM_AW(MEM_AW)) u_win (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re),
    .hst_ofs(hst_ofs), .hst_wdata(hst_wdata),
    .ptr_q(w_ptr), .win_q(w_win),
    .ram_we(w_ram_we), .ram_re(w_ram_re), .ram_addr(w_ram_addr),
    .ram_be(w_ram_be), .ram_wdata(w_ram_wdata), .ram_rdata(w_ram_rdata)
  );

  ecw_ram #(.AW(MEM_AW), .DW(32)) u_ram (
    .clk(clk), .we(w_ram_we), .re(w_ram_re), .addr(w_ram_addr),
    .be(w_ram_be), .wdata(w_ram_wdata), .rdata(w_ram_rdata)
  );

  ecw_intc u_intc (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_ofs(hst_ofs),
    .hst_wdata(hst_wdata), .ctl_c2h_we(ctl_c2h_we),
    .ctl_c2h_data(ctl_c2h_data), .ctl_evt(ctl_evt),
    .h2c_q(w_h2c), .c2h_q(w_c2h), .evt_q(w_evt), .en_q(w_en),
    .irq_q(hst_irq)
  );

  always_comb begin
    case (hst_ofs)
      OFS_H2C:  rd_mux = w_h2c;
      OFS_C2H:  rd_mux = w_c2h;
      OFS_PTRL: rd_mux = w_ptr[7:0];
      OFS_PTRH: rd_mux = w_ptr[15:8];
      4'h4, 4'h5, 4'h6, 4'h7: rd_mux = w_win[hst_ofs[1:0]*8 +: 8];
      OFS_EVTL: rd_mux = w_evt[7:0];
      OFS_EVTH: rd_mux = w_evt[15:8];
      OFS_ENL:  rd_mux = w_en[7:0];
      OFS_ENH:  rd_mux = w_en[15:8];
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (hst_re) rdata_q <= rd_mux;
  end

  assign hst_rdata    = rdata_q;
  assign ctl_h2c_mbox = w_h2c;

endmodule

// File: rtl/ecw_host_window_chk.sv
module ecw_host_window_chk (
  input logic        clk,
  input logic        rst,
  input logic        hst_we,
  input logic [3:0]  hst_ofs,
  input logic [7:0]  hst_wdata,
  input logic        hst_irq,
  input logic        ctl_c2h_we,
  input logic [15:0] ctl_evt,
  input logic [15:0] evt,
  input logic [15:0] en,
  input logic [15:0] ptr,
  input logic        ram_we,
  input logic [3:0]  ram_be
);

  // R10
  irq_gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en == 16'h0) |=> !hst_irq);

  // R9
  evt_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_we && hst_ofs == 4'h8 && ctl_evt[7:0] == 8'h0 && !ctl_c2h_we)
    |=> ((evt[7:0] & $past(hst_wdata)) == 8'h0));

  // R6
  stream_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_we && hst_ofs == 4'h7 && ptr[1:0] == 2'b11)
    |=> (ptr[15:2] == $past(ptr[15:2]) + 14'd1 && ptr[1:0] == 2'b11));

  // R3
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_we && ptr[1:0] == 2'b00) |-> ($countones(ram_be) == 1));

  // R8
  c2h_event_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_c2h_we |=> evt[1]);

  // R5
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    (hst_we && hst_ofs[3:2] != 2'b01) |-> !ram_we);

endmodule

bind ecw_host_window ecw_host_window_chk u_chk (
  .clk(clk), .rst(rst), .hst_we(hst_we), .hst_ofs(hst_ofs),
  .hst_wdata(hst_wdata), .hst_irq(hst_irq), .ctl_c2h_we(ctl_c2h_we),
  .ctl_evt(ctl_evt), .evt(w_evt), .en(w_en), .ptr(w_ptr),
  .ram_we(w_ram_we), .ram_be(w_ram_be)
);

// File: tb/tb_ecw_host_window.sv
`timescale 1ns/1ps
module tb_ecw_host_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_we = 1'b0, hst_re = 1'b0;
  logic [3:0]  hst_ofs = '0;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata;
  logic        hst_irq;
  logic [7:0]  ctl_h2c_mbox;
  logic        ctl_c2h_we = 1'b0;
  logic [7:0]  ctl_c2h_data = '0;
  logic [15:0] ctl_evt = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecw_host_window #(.MEM_AW(6)) dut (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_re(hst_re),
    .hst_ofs(hst_ofs), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_irq(hst_irq), .ctl_h2c_mbox(ctl_h2c_mbox),
    .ctl_c2h_we(ctl_c2h_we), .ctl_c2h_data(ctl_c2h_data), .ctl_evt(ctl_evt)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hwr(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk);
    hst_we = 1'b1; hst_ofs = ofs; hst_wdata = d;
    @(negedge clk);
    hst_we = 1'b0;
    idle(2);
  endtask

  task automatic hrd(input logic [3:0] ofs, output logic [7:0] d);
    @(negedge clk);
    hst_re = 1'b1; hst_ofs = ofs;
    @(negedge clk);
    hst_re = 1'b0;
    d = hst_rdata;
    idle(2);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] ofs, input logic [7:0] exp);
    logic [7:0] v;
    hrd(ofs, v);
    chk(tag, {8'h00, v}, {8'h00, exp});
  endtask

  task automatic set_ptr(input logic [13:0] word, input logic [1:0] mode);
    hwr(4'h2, {word[5:0], mode});
    hwr(4'h3, {2'b00, word[13:6]});
  endtask

  task automatic t_reset();
    for (int o = 0; o < 16; o++) rd_chk("R1 reset read", 4'(o), 8'h00);
    chk("R1 irq", {15'h0, hst_irq}, 16'h0);
    chk("R1 h2c port", {8'h0, ctl_h2c_mbox}, 16'h0);
  endtask

  task automatic t_ptr();
    hwr(4'h2, 8'h41);
    hwr(4'h3, 8'h5A);
    rd_chk("R2 ptr low", 4'h2, 8'h41);
    rd_chk("R2 ptr high", 4'h3, 8'h5A);
    rd_chk("R2 unused offset", 4'hE, 8'h00);
  endtask

  task automatic t_word();
    set_ptr(14'd5, 2'd2);
    for (int j = 0; j < 4; j++) hwr(4'(4 + j), 8'hA0 + 8'(j));
    set_ptr(14'd5, 2'd2);
    for (int j = 0; j < 3; j++) hwr(4'(4 + j), 8'h11 * 8'(j + 1));
    set_ptr(14'd5, 2'd2);
    for (int j = 0; j < 4; j++) rd_chk("R5 word commit at byte 3 only", 4'(4 + j), 8'hA0 + 8'(j));
  endtask

  task automatic t_byte();
    set_ptr(14'd5, 2'd0);
    hwr(4'h6, 8'h5C);
    set_ptr(14'd5, 2'd0);
    rd_chk("R3 byte lane0 kept", 4'h4, 8'hA0);
    rd_chk("R3 byte lane1 kept", 4'h5, 8'hA1);
    rd_chk("R3 byte lane2 written", 4'h6, 8'h5C);
    rd_chk("R3 byte lane3 kept", 4'h7, 8'hA3);
  endtask

  task automatic t_half();
    set_ptr(14'd5, 2'd1);
    hwr(4'h4, 8'h77);
    set_ptr(14'd5, 2'd1);
    rd_chk("R4 even byte alone no commit", 4'h4, 8'hA0);
    hwr(4'h4, 8'h77);
    hwr(4'h5, 8'h88);
    set_ptr(14'd5, 2'd1);
    rd_chk("R4 half low b0", 4'h4, 8'h77);
    rd_chk("R4 half low b1", 4'h5, 8'h88);
    rd_chk("R4 upper half kept b2", 4'h6, 8'h5C);
    rd_chk("R4 upper half kept b3", 4'h7, 8'hA3);
  endtask

  task automatic t_stream();
    set_ptr(14'd8, 2'd3);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 4; j++) hwr(4'(4 + j), 8'h40 + 8'(4 * i + j));
    rd_chk("R6 ptr after write stream", 4'h2, 8'h2F);
    set_ptr(14'd8, 2'd3);
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 4; j++) rd_chk("R6 stream read data", 4'(4 + j), 8'h40 + 8'(4 * i + j));
    rd_chk("R6 ptr after read stream", 4'h2, 8'h2F);
    set_ptr(14'd9, 2'd2);
    rd_chk("R6 middle word via word mode", 4'h4, 8'h44);
  endtask

  task automatic t_h2c();
    hwr(4'h0, 8'h3A);
    rd_chk("R7 h2c readback", 4'h0, 8'h3A);
    chk("R7 h2c port", {8'h0, ctl_h2c_mbox}, 16'h003A);
    rd_chk("R7 event bit0", 4'h8, 8'h01);
    hwr(4'h8, 8'h01);
    rd_chk("R9 bit0 cleared", 4'h8, 8'h00);
  endtask

  task automatic t_c2h();
    logic [7:0] v;
    @(negedge clk);
    ctl_c2h_we = 1'b1; ctl_c2h_data = 8'h96;
    @(negedge clk);
    ctl_c2h_we = 1'b0;
    idle(1);
    hrd(4'h1, v);
    chk("R8 c2h load", {8'h0, v}, 16'h0096);
    rd_chk("R8 event bit1", 4'h8, 8'h02);
    hwr(4'h1, 8'h00);
    rd_chk("R8 zero write no effect", 4'h1, 8'h96);
    hwr(4'h1, v);
    rd_chk("R8 write-back empties", 4'h1, 8'h00);
    hwr(4'h8, 8'h02);
    rd_chk("R9 bit1 cleared", 4'h8, 8'h00);
  endtask

  task automatic t_evt_irq();
    @(negedge clk);
    ctl_evt = 16'h8421;
    @(negedge clk);
    ctl_evt = 16'h0;
    idle(2);
    rd_chk("R9 evt low", 4'h8, 8'h21);
    rd_chk("R9 evt high", 4'h9, 8'h84);
    chk("R10 irq with enables zero", {15'h0, hst_irq}, 16'h0);
    hwr(4'h9, 8'h00);
    rd_chk("R9 zero write keeps high", 4'h9, 8'h84);
    @(negedge clk);
    hst_we = 1'b1; hst_ofs = 4'hA; hst_wdata = 8'h20;
    @(negedge clk);
    hst_we = 1'b0;
    chk("R10 irq not yet", {15'h0, hst_irq}, 16'h0);
    @(negedge clk);
    chk("R10 irq one edge later", {15'h0, hst_irq}, 16'h1);
    idle(1);
    rd_chk("R10 enable low readback", 4'hA, 8'h20);
    rd_chk("R10 enable high readback", 4'hB, 8'h00);
    hwr(4'h8, 8'h20);
    rd_chk("R9 per-bit clear low", 4'h8, 8'h01);
    rd_chk("R9 high byte untouched", 4'h9, 8'h84);
    chk("R10 irq drops", {15'h0, hst_irq}, 16'h0);
    hwr(4'hB, 8'h80);
    chk("R10 irq via high enable", {15'h0, hst_irq}, 16'h1);
    hwr(4'h9, 8'h80);
    chk("R10 irq after clear", {15'h0, hst_irq}, 16'h0);
    rd_chk("R9 high after clear", 4'h9, 8'h04);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_ptr();
    t_word();
    t_byte();
    t_half();
    t_stream();
    t_h2c();
    t_c2h();
    t_evt_irq();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule